// File: doc/BRIEF.md
# Event Synchronisation Unit

This block keeps a small table of event objects. Lightweight threads use them to synchronise with each other, and they can also raise an interrupt to the host. A caller sends one operation per cycle: wait, set, clear or test on a chosen event. The block answers each operation with a result code, together with the state the event's flag had before the operation.

Each event holds a set flag and a first-in, first-out queue of suspended actions. A wait on an event that is not set places the caller's action at the tail of that queue. A later set consumes the head action and fires it on one of three output ports:

- a local thread identifier is pushed to the run queue;
- a reschedule message goes to a remote node;
- a host interrupt is raised, tagged with the event number.

Top module: `evsync_unit`

## Requirements
- R1: After reset every event is unset with an empty queue, and rsp_valid, rq_valid, rmt_valid and irq_valid are all low.
- R2: op_ready is always high. Every accepted operation (op_valid and op_ready high at a clock edge) produces exactly one rsp_valid pulse in the following cycle. rsp_flag gives the event's set flag as it was before that operation.
- R3: A wait (op_code 0) on a set event returns code 0 (OK) and leaves the event unset.
- R4: A wait on an unset event whose queue holds fewer than 4 actions returns code 1 (SUSPENDED) and appends the action {op_kind, op_node, op_tid} at the queue tail.
- R5: A wait on an unset event whose queue already holds 4 actions returns code 2 (OVERFLOW) and leaves the queue unchanged.
- R6: A set (op_code 1) on an event with an empty queue returns code 0, marks the event set and fires no action.
- R7: A set on an event with a non-empty queue returns code 0 and removes exactly the head action, in arrival order. That action appears on an output port in the cycle of the response. The event stays unset.
- R8: The action kind selects the port. Kind 0 gives rq_valid with rq_tid = thread id. Kind 1 gives rmt_valid with rmt_node and rmt_tid. Kinds 2 and 3 give irq_valid with irq_event = the event number. At most one action fires per cycle.
- R9: A clear (op_code 2) returns code 0, leaves the event unset and does not change its queue.
- R10: A test (op_code 3) returns code 0 and reports the flag in rsp_flag without changing the flag or the queue.
- R11: An operation changes only the event named by op_event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation present |
| op_ready | output | 1 | Operation can be accepted (always high) |
| op_code | input | 2 | 0 wait, 1 set, 2 clear, 3 test |
| op_event | input | 4 | Event index |
| op_kind | input | 2 | Action kind queued by a suspending wait |
| op_node | input | 4 | Remote node for the queued action |
| op_tid | input | 8 | Thread identifier for the queued action |
| rsp_valid | output | 1 | Response present |
| rsp_code | output | 2 | 0 OK, 1 SUSPENDED, 2 OVERFLOW |
| rsp_flag | output | 1 | Event flag before the operation |
| rq_valid | output | 1 | Push a thread onto the local run queue |
| rq_tid | output | 8 | Thread to resume |
| rmt_valid | output | 1 | Remote reschedule message |
| rmt_node | output | 4 | Destination node |
| rmt_tid | output | 8 | Remote thread |
| irq_valid | output | 1 | Host interrupt pulse |
| irq_event | output | 4 | Event that raised the interrupt |

## Verification
The hardest state to reach is an event whose queue is full. A wait in that state must be refused. After that, sets must drain the queue in the order it filled. Sets that arrive after the queue is empty must then latch the flag instead of firing an action.

The stimulus reaches this state on every one of the 16 events. It first consumes any set flag with a wait, then issues four waits that cycle through the three action kinds, then a fifth wait that must overflow. A clear and a test follow to show the queue survived untouched. Five sets then drain the four actions and latch the flag. Finally, waits spread across two events show that the queues stay separate.

// File: rtl/evsync_pkg.sv
package evsync_pkg;
    localparam int EV_N    = 16;
    localparam int Q_DEPTH = 4;
    localparam int TID_W   = 8;
    localparam int NODE_W  = 4;

    typedef enum logic [1:0] {OP_WAIT = 2'd0, OP_SET = 2'd1, OP_CLEAR = 2'd2, OP_TEST = 2'd3} op_e;
    typedef enum logic [1:0] {RES_OK = 2'd0, RES_SUSP = 2'd1, RES_OVF = 2'd2} res_e;

    typedef struct packed {
        logic [1:0]        kind;
        logic [NODE_W-1:0] node;
        logic [TID_W-1:0]  tid;
    } act_t;
endpackage

// File: rtl/evsync_slot.sv
module evsync_slot import evsync_pkg::*; #(
    parameter int DEPTH = Q_DEPTH
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    input  op_e  op,
    input  act_t act_in,
    output logic flag_o,
    output logic empty_o,
    output logic full_o,
    output act_t head_o
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic          flag;
        logic [PW-1:0] rd;
        logic [PW-1:0] wr;
        logic [CW-1:0] cnt;
    } slot_s;

    slot_s s_d, s_q;
    act_t  mem_d [DEPTH];
    act_t  mem_q [DEPTH];

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign flag_o  = s_q.flag;
    assign empty_o = (s_q.cnt == '0);
    assign full_o  = (s_q.cnt == CW'(DEPTH));
    assign head_o  = mem_q[s_q.rd];

    always_comb begin
        s_d   = s_q;
        mem_d = mem_q;
        if (sel) begin
            unique case (op)
                OP_WAIT: begin
                    if (s_q.flag) begin
                        s_d.flag = 1'b0;
                    end else if (!full_o) begin
                        mem_d[s_q.wr] = act_in;
                        s_d.wr        = bump(s_q.wr);
                        s_d.cnt       = s_q.cnt + 1'b1;
                    end
                end
                OP_SET: begin
                    if (!empty_o) begin
                        s_d.rd  = bump(s_q.rd);
                        s_d.cnt = s_q.cnt - 1'b1;
                    end else begin
                        s_d.flag = 1'b1;
                    end
                end
                OP_CLEAR: s_d.flag = 1'b0;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q   <= '0;
            mem_q <= '{default: '0};
        end else begin
            s_q   <= s_d;
            mem_q <= mem_d;
        end
    end
endmodule

// File: rtl/evsync_unit.sv
module evsync_unit import evsync_pkg::*; #(
    parameter int N_EV  = EV_N,
    parameter int DEPTH = Q_DEPTH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    output logic              op_ready,
    input  logic [1:0]        op_code,
    input  logic [3:0]        op_event,
    input  logic [1:0]        op_kind,
    input  logic [NODE_W-1:0] op_node,
    input  logic [TID_W-1:0]  op_tid,
    output logic              rsp_valid,
    output logic [1:0]        rsp_code,
    output logic              rsp_flag,
    output logic              rq_valid,
    output logic [TID_W-1:0]  rq_tid,
    output logic              rmt_valid,
    output logic [NODE_W-1:0] rmt_node,
    output logic [TID_W-1:0]  rmt_tid,
    output logic              irq_valid,
    output logic [3:0]        irq_event
);
    typedef struct packed {
        logic              rsp_valid;
        logic [1:0]        rsp_code;
        logic              rsp_flag;
        logic              rq_valid;
        logic [TID_W-1:0]  rq_tid;
        logic              rmt_valid;
        logic [NODE_W-1:0] rmt_node;
        logic [TID_W-1:0]  rmt_tid;
        logic              irq_valid;
        logic [3:0]        irq_event;
    } out_s;

    out_s o_d, o_q;
    logic fire;
    op_e  op;
    act_t act_in;
    logic flag_w  [N_EV];
    logic empty_w [N_EV];
    logic full_w  [N_EV];
    act_t head_w  [N_EV];

    assign op_ready = 1'b1;
    assign fire     = op_valid && op_ready;
    assign op       = op_e'(op_code);
    assign act_in   = '{kind: op_kind, node: op_node, tid: op_tid};

    for (genvar g = 0; g < N_EV; g++) begin : g_slot
        evsync_slot #(.DEPTH(DEPTH)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .sel     (fire && (op_event == 4'(g))),
            .op      (op),
            .act_in  (act_in),
            .flag_o  (flag_w[g]),
            .empty_o (empty_w[g]),
            .full_o  (full_w[g]),
            .head_o  (head_w[g])
        );
    end

    always_comb begin
        o_d = '0;
        if (fire) begin
            o_d.rsp_valid = 1'b1;
            o_d.rsp_flag  = flag_w[op_event];
            o_d.rsp_code  = RES_OK;
            if (op == OP_WAIT && !flag_w[op_event]) begin
                o_d.rsp_code = full_w[op_event] ? RES_OVF : RES_SUSP;
            end
            if (op == OP_SET && !empty_w[op_event]) begin
                unique case (head_w[op_event].kind)
                    2'd0: begin
                        o_d.rq_valid = 1'b1;
                        o_d.rq_tid   = head_w[op_event].tid;
                    end
                    2'd1: begin
                        o_d.rmt_valid = 1'b1;
                        o_d.rmt_node  = head_w[op_event].node;
                        o_d.rmt_tid   = head_w[op_event].tid;
                    end
                    default: begin
                        o_d.irq_valid = 1'b1;
                        o_d.irq_event = op_event;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign rsp_valid = o_q.rsp_valid;
    assign rsp_code  = o_q.rsp_code;
    assign rsp_flag  = o_q.rsp_flag;
    assign rq_valid  = o_q.rq_valid;
    assign rq_tid    = o_q.rq_tid;
    assign rmt_valid = o_q.rmt_valid;
    assign rmt_node  = o_q.rmt_node;
    assign rmt_tid   = o_q.rmt_tid;
    assign irq_valid = o_q.irq_valid;
    assign irq_event = o_q.irq_event;
endmodule

// File: rtl/evsync_chk.sv
module evsync_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       op_valid,
    input logic       op_ready,
    input logic [1:0] op_code,
    input logic       rsp_valid,
    input logic [1:0] rsp_code,
    input logic       rsp_flag,
    input logic       rq_valid,
    input logic       rmt_valid,
    input logic       irq_valid
);
    logic fire;
    logic act;
    assign fire = op_valid && op_ready;
    assign act  = rq_valid || rmt_valid || irq_valid;

    AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n) fire |=> rsp_valid); // R2
    AST_NO_STRAY_RSP: assert property (@(posedge clk) disable iff (!rst_n) !fire |=> !rsp_valid); // R2
    AST_SUSP_ONLY_UNSET: assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && rsp_code == 2'd1) |-> !rsp_flag); // R4
    AST_NO_OVERFLOW_WHEN_SET: assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && rsp_code == 2'd2) |-> !rsp_flag); // R5
    AST_ACTION_FROM_SET: assert property (@(posedge clk) disable iff (!rst_n) act |-> $past(fire && op_code == 2'd1)); // R7
    AST_ACTION_UNSET_OK: assert property (@(posedge clk) disable iff (!rst_n) act |-> (rsp_valid && rsp_code == 2'd0 && !rsp_flag)); // R7
    AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({rq_valid, rmt_valid, irq_valid})); // R8
    AST_TEST_OK: assert property (@(posedge clk) disable iff (!rst_n) (fire && op_code == 2'd3) |=> (rsp_code == 2'd0)); // R10
endmodule

bind evsync_unit evsync_chk u_evsync_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_ready  (op_ready),
    .op_code   (op_code),
    .rsp_valid (rsp_valid),
    .rsp_code  (rsp_code),
    .rsp_flag  (rsp_flag),
    .rq_valid  (rq_valid),
    .rmt_valid (rmt_valid),
    .irq_valid (irq_valid)
);

// File: tb/test_evsync_unit.sv
module test_evsync_unit;
    localparam int CLK_PERIOD = 10;
    localparam int NE = 16;
    localparam int QD = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic       op_ready;
    logic [1:0] op_code = '0;
    logic [3:0] op_event = '0;
    logic [1:0] op_kind = '0;
    logic [3:0] op_node = '0;
    logic [7:0] op_tid = '0;
    logic       rsp_valid, rsp_flag, rq_valid, rmt_valid, irq_valid;
    logic [1:0] rsp_code;
    logic [7:0] rq_tid, rmt_tid;
    logic [3:0] rmt_node, irq_event;

    int total = 0;
    int bad = 0;

    bit          m_flag [NE];
    int          m_cnt  [NE];
    logic [13:0] m_q    [NE][QD];

    always #(CLK_PERIOD/2) clk = ~clk;

    evsync_unit i_evsync_unit (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
        .op_code(op_code), .op_event(op_event), .op_kind(op_kind),
        .op_node(op_node), .op_tid(op_tid), .rsp_valid(rsp_valid),
        .rsp_code(rsp_code), .rsp_flag(rsp_flag), .rq_valid(rq_valid),
        .rq_tid(rq_tid), .rmt_valid(rmt_valid), .rmt_node(rmt_node),
        .rmt_tid(rmt_tid), .irq_valid(irq_valid), .irq_event(irq_event)
    );

    task automatic chk(input int act, input int exp, input string req, input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_op(input int op, input int ev, input int kind, input int node,
                         input int tid, input string req);
        int          e_code = 0;
        int          e_flag = m_flag[ev];
        int          e_rq = 0, e_rmt = 0, e_irq = 0;
        logic [13:0] h = '0;
        case (op)
            0: begin
                if (m_flag[ev]) m_flag[ev] = 0;
                else if (m_cnt[ev] < QD) begin
                    m_q[ev][m_cnt[ev]] = {2'(kind), 4'(node), 8'(tid)};
                    m_cnt[ev]++;
                    e_code = 1;
                end else e_code = 2;
            end
            1: begin
                if (m_cnt[ev] > 0) begin
                    h = m_q[ev][0];
                    for (int i = 0; i < QD - 1; i++) m_q[ev][i] = m_q[ev][i+1];
                    m_cnt[ev]--;
                    if (h[13:12] == 2'd0) e_rq = 1;
                    else if (h[13:12] == 2'd1) e_rmt = 1;
                    else e_irq = 1;
                end else m_flag[ev] = 1;
            end
            2: m_flag[ev] = 0;
            default: ;
        endcase
        @(negedge clk);
        op_valid = 1'b1; op_code = 2'(op); op_event = 4'(ev);
        op_kind = 2'(kind); op_node = 4'(node); op_tid = 8'(tid);
        @(posedge clk);
        @(negedge clk);
        op_valid = 1'b0;
        chk(int'(op_ready), 1, "R2", "op_ready");
        chk(int'(rsp_valid), 1, "R2", "rsp_valid");
        chk(int'(rsp_flag), e_flag, "R2", "rsp_flag");
        chk(int'(rsp_code), e_code, req, "rsp_code");
        chk(int'(rq_valid), e_rq, "R8", "rq_valid");
        chk(int'(rmt_valid), e_rmt, "R8", "rmt_valid");
        chk(int'(irq_valid), e_irq, "R8", "irq_valid");
        if (e_rq == 1) chk(int'(rq_tid), int'(h[7:0]), "R7", "rq_tid");
        if (e_rmt == 1) begin
            chk(int'(rmt_tid), int'(h[7:0]), "R7", "rmt_tid");
            chk(int'(rmt_node), int'(h[11:8]), "R8", "rmt_node");
        end
        if (e_irq == 1) chk(int'(irq_event), ev, "R8", "irq_event");
        @(negedge clk);
        chk(int'(rsp_valid), 0, "R2", "idle rsp_valid");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int e = 0; e < NE; e++) begin
            m_flag[e] = 0;
            m_cnt[e] = 0;
        end
        repeat (3) @(negedge clk);
        chk(int'(rsp_valid), 0, "R1", "reset rsp_valid");
        chk(int'(rq_valid | rmt_valid | irq_valid), 0, "R1", "reset actions");
        rst_n = 1'b1;
        for (int e = 0; e < NE; e++) do_op(3, e, 0, 0, 0, "R1");
        for (int e = 0; e < NE; e++) begin
            do_op(1, e, 0, 0, 0, "R6");
            do_op(3, e, 0, 0, 0, "R10");
            do_op(3, e, 0, 0, 0, "R10");
            do_op(0, e, 0, 0, 0, "R3");
            for (int i = 0; i < QD; i++)
                do_op(0, e, (e + i) % 3, (e + 3 * i) % 16, e * 16 + i, "R4");
            do_op(0, e, 2, 1, 255, "R5");
            do_op(2, e, 0, 0, 0, "R9");
            do_op(3, e, 0, 0, 0, "R9");
            for (int i = 0; i < QD; i++) do_op(1, e, 0, 0, 0, "R7");
            do_op(3, e, 0, 0, 0, "R7");
            do_op(1, e, 0, 0, 0, "R6");
            do_op(2, e, 0, 0, 0, "R9");
            do_op(1, e, 0, 0, 0, "R6");
            do_op(0, e, 0, 0, 0, "R3");
        end
        do_op(0, 2, 0, 0, 17, "R11");
        do_op(0, 5, 1, 9, 33, "R11");
        do_op(0, 2, 3, 0, 18, "R11");
        do_op(1, 5, 0, 0, 0, "R11");
        do_op(1, 2, 0, 0, 0, "R11");
        do_op(1, 7, 0, 0, 0, "R11");
        do_op(1, 2, 0, 0, 0, "R11");
        do_op(1, 5, 0, 0, 0, "R11");
        for (int e = 0; e < NE; e++) do_op(3, e, 0, 0, 0, "R11");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule